// File: doc/BRIEF.md
# PLL Sample-Rate Divider Encoder

This block turns a requested audio sample rate, given in hertz, into the 12-bit control word of a synthesizer whose reference runs at 28.224 MHz. It also reports the sample rate that the encoded divider really produces. Small dividers are written at full resolution behind a range prefix. Larger dividers lose one or two low bits so that the word still fits in 12 bits. The realized rate is therefore recomputed from the divider after those bits are dropped.

A request arrives on a valid/ready handshake. `req_ready` is high only while the block is idle. Holding `req_valid` high while `req_ready` is low has no effect: the request is neither taken nor queued. A producer that wants back-pressure simply holds its request until `req_ready` returns. An in-range request runs two passes through one shared restoring divider, about 57 cycles in total. An out-of-range request is answered on the next cycle. The result side has no back-pressure. `res_valid` pulses for one cycle, and the result fields hold their values until the next pulse. `req_ready` is already high in the cycle in which a result pulses, so a new request can be taken in that same cycle.

Top module: `pll_rate_enc`

## Requirements
- R1: A request below 6900 Hz or above 219000 Hz is answered with `res_err`=1, word 0 and rate 0, one cycle after it is accepted. Exactly 6900 Hz and exactly 219000 Hz are accepted as valid rates.
- R2: For a valid rate f, the divider is D = (floor(56448000 / f) − 1) / 2, using integer division.
- R3: For D < 0x100, the word is 0xC00 + D. For 0x100 ≤ D < 0x200, the word is 0x800 + D. In both cases the adjusted divider A equals D.
- R4: For 0x200 ≤ D < 0x400, the word is D mod 0x200 and A equals D.
- R5: For 0x400 ≤ D < 0x800, the word is 0x200 + ((D >> 1) mod 0x200) and A is D with bit 0 cleared.
- R6: For D ≥ 0x800, the word is 0x400 + ((D >> 2) mod 0x200) and A is D with bits 1:0 cleared.
- R7: For a valid rate, `res_rate` = floor(28224000 / (A + 1)) and `res_err` = 0.
- R8: `res_word_hi` carries word bits 11:8 and `res_word_lo` carries word bits 7:0.
- R9: After an in-range request is accepted, `req_ready` stays low until its result pulses. Requests offered during that time are ignored, and each accepted request yields exactly one result.
- R10: `res_valid` lasts one cycle per result. The result fields change only in a cycle where `res_valid` is high.
- R11: During and right after reset, `req_ready`=1, `res_valid`=0 and all result fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle; request taken when both are high |
| req_freq | input | 18 | Requested sample rate in Hz |
| res_valid | output | 1 | One-cycle result pulse |
| res_err | output | 1 | Requested rate out of range |
| res_word_hi | output | 4 | Control word bits 11:8 |
| res_word_lo | output | 8 | Control word bits 7:0 |
| res_rate | output | 18 | Realized sample rate in Hz |

## Verification
Two events can fall in the same cycle: the delivery of one result and the acceptance of the next request. This happens because `req_ready` rises in the same cycle as `res_valid`. The bench provokes it by holding `req_valid` high across a chain of back-to-back requests, including error requests that finish in one cycle. It then judges the case in three ways: it counts the cycles where the overlap occurred, it checks that every queued expectation is matched in order, and it checks that no result appears without an accepted request.

// File: rtl/pll_rate_enc_pkg.sv
package pll_rate_enc_pkg;
  localparam int unsigned REF_HZ   = 28_224_000;
  localparam int unsigned FREQ_MIN = 6_900;
  localparam int unsigned FREQ_MAX = 219_000;
  localparam int unsigned WORD_W   = 12;
  localparam int unsigned FIELD_W  = 9;
  localparam int unsigned DIV_W    = 13;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DIVA  = 2'd1,
    ST_ENC   = 2'd2,
    ST_DIVB  = 2'd3
  } enc_state_t;
endpackage

// File: rtl/pll_seq_divider.sv
module pll_seq_divider #(
  parameter int unsigned NUM_W = 26,
  parameter int unsigned DEN_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] dividend,
  input  logic [DEN_W-1:0] divisor,
  output logic             done,
  output logic [NUM_W-1:0] quotient
);
  localparam int unsigned REM_W = DEN_W + 1;
  localparam int unsigned CNT_W = $clog2(NUM_W + 1);

  logic [REM_W-1:0] rem_q;
  logic [DEN_W-1:0] den_q;
  logic [NUM_W-1:0] quo_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [REM_W-1:0] shifted;
  logic [REM_W:0]   trial;

  always_comb begin
    shifted = {rem_q[REM_W-2:0], quo_q[NUM_W-1]};
    trial   = {1'b0, shifted} - {2'b00, den_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy_q) begin
        rem_q  <= '0;
        den_q  <= divisor;
        quo_q  <= dividend;
        cnt_q  <= CNT_W'(NUM_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (!trial[REM_W]) begin
          rem_q <= trial[REM_W-1:0];
          quo_q <= {quo_q[NUM_W-2:0], 1'b1};
        end else begin
          rem_q <= shifted;
          quo_q <= {quo_q[NUM_W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  assign quotient = quo_q;

  // R2: the remainder left at completion is smaller than the divisor
  assert_rem_below_den_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rem_q < {1'b0, den_q}));

  // R9: a completion pulse never repeats on consecutive cycles
  assert_single_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/pll_word_encoder.sv
module pll_word_encoder
  import pll_rate_enc_pkg::*;
#(
  parameter int unsigned D_W = DIV_W,
  parameter int unsigned W_W = WORD_W,
  parameter int unsigned F_W = FIELD_W
) (
  input  logic [D_W-1:0] div_in,
  output logic [W_W-1:0] word,
  output logic [D_W-1:0] adj
);
  localparam int unsigned LIM_A = 1 << (F_W - 1);
  localparam int unsigned LIM_B = 1 << F_W;
  localparam int unsigned LIM_C = 1 << (F_W + 1);
  localparam int unsigned LIM_D = 1 << (F_W + 2);
  localparam logic [W_W-1:0] PFX_FINE  = W_W'(12'hC00);
  localparam logic [W_W-1:0] PFX_MID   = W_W'(12'h800);
  localparam logic [W_W-1:0] PFX_HALF  = W_W'(12'h200);
  localparam logic [W_W-1:0] PFX_QUART = W_W'(12'h400);

  logic [F_W-1:0] fld_full, fld_half, fld_quart;

  always_comb begin
    fld_full  = div_in[F_W-1:0];
    fld_half  = div_in[F_W:1];
    fld_quart = div_in[F_W+1:2];
    if (div_in < D_W'(LIM_A)) begin
      word = PFX_FINE + W_W'(div_in);
      adj  = div_in;
    end else if (div_in < D_W'(LIM_B)) begin
      word = PFX_MID + W_W'(div_in);
      adj  = div_in;
    end else if (div_in < D_W'(LIM_C)) begin
      word = W_W'(fld_full);
      adj  = div_in;
    end else if (div_in < D_W'(LIM_D)) begin
      word = PFX_HALF + W_W'(fld_half);
      adj  = {div_in[D_W-1:1], 1'b0};
    end else begin
      word = PFX_QUART + W_W'(fld_quart);
      adj  = {div_in[D_W-1:2], 2'b00};
    end
  end

  // R5 / R6: the adjusted divider never exceeds the divider and drops at most two
  always_comb begin
    assert_adj_close_R6: assert ((adj <= div_in) && ((div_in - adj) < D_W'(4)));
    if (div_in < D_W'(LIM_A))
      assert_fine_prefix_R3: assert (word[W_W-1 -: 2] == 2'b11);
  end
endmodule

// File: rtl/pll_rate_enc.sv
module pll_rate_enc
  import pll_rate_enc_pkg::*;
#(
  parameter int unsigned FREQ_W = 18,
  parameter int unsigned RATE_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [FREQ_W-1:0] req_freq,
  output logic              res_valid,
  output logic              res_err,
  output logic [3:0]        res_word_hi,
  output logic [7:0]        res_word_lo,
  output logic [RATE_W-1:0] res_rate
);
  localparam int unsigned NUM_W = $clog2(2 * REF_HZ + 1);
  localparam logic [NUM_W-1:0] NUM_DOUBLE = NUM_W'(2 * REF_HZ);
  localparam logic [NUM_W-1:0] NUM_SINGLE = NUM_W'(REF_HZ);

  enc_state_t        state_q;
  logic [DIV_W-1:0]  div_q;
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] enc_word;
  logic [DIV_W-1:0]  enc_adj;
  logic              in_range;
  logic              accept;
  logic              dv_start;
  logic              dv_done;
  logic [NUM_W-1:0]  dv_num;
  logic [FREQ_W-1:0] dv_den;
  logic [NUM_W-1:0]  dv_quo;
  logic [NUM_W-1:0]  quo_less;

  assign req_ready = (state_q == ST_IDLE);
  assign in_range  = (req_freq >= FREQ_W'(FREQ_MIN)) && (req_freq <= FREQ_W'(FREQ_MAX));
  assign accept    = req_valid && req_ready;
  assign quo_less  = dv_quo - NUM_W'(1);

  always_comb begin
    dv_start = 1'b0;
    dv_num   = NUM_SINGLE;
    dv_den   = FREQ_W'(enc_adj) + FREQ_W'(1);
    if (state_q == ST_IDLE) begin
      dv_start = accept && in_range;
      dv_num   = NUM_DOUBLE;
      dv_den   = req_freq;
    end else if (state_q == ST_ENC) begin
      dv_start = 1'b1;
    end
  end

  pll_seq_divider #(.NUM_W(NUM_W), .DEN_W(FREQ_W)) divider_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (dv_start),
    .dividend (dv_num),
    .divisor  (dv_den),
    .done     (dv_done),
    .quotient (dv_quo)
  );

  pll_word_encoder encoder_i (
    .div_in (div_q),
    .word   (enc_word),
    .adj    (enc_adj)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      div_q       <= '0;
      word_q      <= '0;
      res_valid   <= 1'b0;
      res_err     <= 1'b0;
      res_word_hi <= '0;
      res_word_lo <= '0;
      res_rate    <= '0;
    end else begin
      res_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (in_range) begin
              state_q <= ST_DIVA;
            end else begin
              res_valid   <= 1'b1;
              res_err     <= 1'b1;
              res_word_hi <= '0;
              res_word_lo <= '0;
              res_rate    <= '0;
            end
          end
        end
        ST_DIVA: begin
          if (dv_done) begin
            div_q   <= quo_less[DIV_W:1];
            state_q <= ST_ENC;
          end
        end
        ST_ENC: begin
          word_q  <= enc_word;
          state_q <= ST_DIVB;
        end
        ST_DIVB: begin
          if (dv_done) begin
            res_valid   <= 1'b1;
            res_err     <= 1'b0;
            res_word_hi <= word_q[WORD_W-1:8];
            res_word_lo <= word_q[7:0];
            res_rate    <= dv_quo[RATE_W-1:0];
            state_q     <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9: an accepted in-range request closes the intake on the next cycle
  assert_busy_after_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_range) |=> !req_ready);

  // R1: an accepted out-of-range request is answered next cycle as an error
  assert_reject_answer_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_range) |=> (res_valid && res_err && res_rate == '0));

  // R10: result fields hold still between result pulses
  assert_hold_fields_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_rate) && $stable(res_word_hi) && $stable(res_word_lo)
                    && $stable(res_err)));

  // R7: a valid result never reports an error and a nonzero rate
  assert_good_rate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_err) |-> (res_rate != '0));
endmodule

// File: tb/pll_rate_enc_tb_top.sv
`timescale 1ns/1ps
module pll_rate_enc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [17:0] req_freq = '0;
  logic        res_valid;
  logic        res_err;
  logic [3:0]  res_word_hi;
  logic [7:0]  res_word_lo;
  logic [17:0] res_rate;

  int checks = 0;
  int errors = 0;
  int accepted = 0;
  int results = 0;
  int overlaps = 0;
  bit finished = 1'b0;

  bit    q_err[$];
  int    q_word[$];
  int    q_rate[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  pll_rate_enc dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_freq(req_freq), .res_valid(res_valid), .res_err(res_err),
    .res_word_hi(res_word_hi), .res_word_lo(res_word_lo), .res_rate(res_rate)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Expected result from the requirements (R1..R7)
  task automatic model(input int f, output bit e, output int w, output int r, output string tag);
    int q, d, a;
    if (f < 6900 || f > 219000) begin
      e = 1; w = 0; r = 0; tag = "R1"; return;
    end
    e = 0;
    q = 56448000 / f;
    d = (q - 1) / 2;
    if (d < 'h100)      begin w = 'hC00 + d; a = d; tag = "R3"; end
    else if (d < 'h200) begin w = 'h800 + d; a = d; tag = "R3"; end
    else if (d < 'h400) begin w = d & 'h1FF; a = d; tag = "R4"; end
    else if (d < 'h800) begin w = 'h200 + ((d >> 1) & 'h1FF); a = d & ~1; tag = "R5"; end
    else                begin w = 'h400 + ((d >> 2) & 'h1FF); a = d & ~3; tag = "R6"; end
    r = 28224000 / (a + 1);
  endtask

  // Driver: caller is at a negedge; valid stays high into a following call
  task automatic send(input int f, input bit poke);
    bit e; int w, r; string tag;
    req_valid = 1'b1;
    req_freq  = 18'(f);
    while (!req_ready) @(negedge clk);
    model(f, e, w, r, tag);
    q_err.push_back(e); q_word.push_back(w); q_rate.push_back(r); q_tag.push_back(tag);
    accepted++;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (poke && !e) begin
      for (int k = 0; k < 3; k++) begin
        req_valid = 1'b1;
        req_freq  = 18'(44100 + k);
        check(!req_ready, "R9 ready low while busy", req_ready, 0);
        @(negedge clk);
      end
      req_valid = 1'b0;
    end
  endtask

  // Monitor / scoreboard
  logic [3:0]  last_hi = '0;
  logic [7:0]  last_lo = '0;
  logic [17:0] last_rate = '0;
  bit          last_v = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (res_valid && req_valid && req_ready) overlaps++;
      if (res_valid) begin
        results++;
        check(!(last_v && res_valid && !res_err && dut_i.req_ready == 1'b0), "R10 pulse", 0, 0);
        if (q_err.size() == 0) begin
          check(1'b0, "R9 result without request", results, accepted);
        end else begin
          bit e; int w, r; string tag;
          e = q_err.pop_front(); w = q_word.pop_front(); r = q_rate.pop_front();
          tag = q_tag.pop_front();
          check(res_err == e, {tag, " R1 err flag"}, res_err, e);
          check({res_word_hi, res_word_lo} == 12'(w), {tag, " R2 R8 word"},
                {res_word_hi, res_word_lo}, w);
          check(res_rate == 18'(r), {tag, " R7 rate"}, res_rate, r);
        end
        last_hi = res_word_hi; last_lo = res_word_lo; last_rate = res_rate;
      end else begin
        check(res_word_hi == last_hi && res_word_lo == last_lo && res_rate == last_rate,
              "R10 fields hold", res_rate, last_rate);
      end
      last_v = res_valid;
    end
  end

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    check(1'b0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R11: reset state
    check(req_ready == 1'b1 && res_valid == 1'b0, "R11 reset handshake", {req_ready, res_valid}, 2'b10);
    check(res_rate == 0 && {res_word_hi, res_word_lo} == 0 && !res_err, "R11 reset fields", res_rate, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && res_valid == 1'b0, "R11 after reset", {req_ready, res_valid}, 2'b10);
    // Isolated requests over every divider range, with busy pokes (R9)
    send(219000, 1'b1);  // R3 upper bound accepted, D=128
    repeat (70) @(negedge clk);
    send(150000, 1'b1);  // R3
    repeat (70) @(negedge clk);
    send(100000, 1'b0);  // R3 mid prefix
    repeat (70) @(negedge clk);
    send(48000, 1'b1);   // R4
    repeat (70) @(negedge clk);
    send(22050, 1'b0);   // R5
    repeat (70) @(negedge clk);
    send(8000, 1'b0);    // R6
    repeat (70) @(negedge clk);
    send(6900, 1'b0);    // R1 lower bound accepted, R6
    repeat (70) @(negedge clk);
    send(6899, 1'b0);    // R1 below range
    repeat (3) @(negedge clk);
    send(219001, 1'b0);  // R1 above range
    repeat (3) @(negedge clk);
    // Back-to-back chain: result and next acceptance share a cycle
    send(44100, 1'b0);
    send(96000, 1'b0);
    send(0, 1'b0);
    send(262143, 1'b0);
    send(32000, 1'b0);
    send(11025, 1'b0);
    send(192000, 1'b0);
    send(16000, 1'b0);
    repeat (80) @(negedge clk);
    check(q_err.size() == 0, "R9 all results delivered", q_err.size(), 0);
    check(results == accepted, "R9 one result per request", results, accepted);
    check(overlaps > 0, "R9 result/accept overlap seen", overlaps, 1);
    summary();
  end
endmodule